// File: doc/BRIEF.md
# Counter-Based LRU Way Tracker

This block keeps the replacement state for every set of an N-way set-associative cache. The cache controller tells it which way of which set was hit, which way was just filled after a miss, and which way was invalidated. For any set the controller names on the query input, it returns the way to replace next. Tags, data and memory traffic stay in the controller. The tracker sees only set and way indices.

Each way keeps a small saturating age counter and a valid flag. The counter runs from 0 up to U-1, where U is the number of usage states, a parameter. The most recently touched way holds U-1. Ways that have aged out sit at 0. A hit and a fill age the other ways by different rules: a hit ages only the ways that were younger than the one hit, while a fill ages every way whose counter is not yet at zero.

The victim output is combinational from the stored state of the queried set. Updates take effect at the next rising clock edge, so a query in the same cycle as an update still sees the state from before that update.

Top module: `lru_age_tracker`

## Requirements
- R1: On a hit update to way W of set S, every other way of S whose counter is strictly greater than W's counter before the update is decremented by one, and W's counter becomes U-1 after the clock edge. Ways of S whose counter is equal to or below W's are left unchanged.
- R2: On a fill update to way W of set S, every other way of S with a non-zero counter is decremented by one. After the clock edge, W's counter becomes U-1 and W is marked valid.
- R3: A counter that is 0 stays 0 under any hit or fill that targets another way. Counters never wrap below zero.
- R4: An invalidate of way W of set S sets W's counter to 0 and marks W invalid at the next clock edge.
- R5: Every counter always lies in the range 0 to U-1. With the default U = 3 the counters are 2 bits wide, so the encoding 3 is never stored.
- R6: The victim for the queried set is chosen as follows:
  - If the set has an invalid way, the victim is the lowest-numbered invalid way and `victim_free` is 1.
  - Otherwise the victim is the way with the smallest counter, ties going to the lowest way index, and `victim_free` is 0.
- R7: A hit update and a fill update to different sets in the same cycle both take effect. A hit and a fill to the same set in the same cycle is illegal and is flagged by an assertion.
- R8: When an invalidate targets the same set and way as a hit or fill in the same cycle, the other ways of the set are still aged by the hit or fill rule, and the invalidate decides the final state of that way: counter 0, invalid.
- R9: `victim_way` and `victim_free` follow `query_set` with no clock in between. An update applied in a cycle is not visible on the victim outputs until after the next rising edge.
- R10: While `rst` is high at a rising edge, every counter is cleared to 0 and every way is marked invalid. After reset, every set reports victim way 0 with `victim_free` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hit_en | input | 1 | Hit update strobe |
| hit_set | input | SW = clog2(NUM_SETS) | Set index of the hit |
| hit_way | input | WW = clog2(NUM_WAYS) | Way index of the hit |
| fill_en | input | 1 | Fill update strobe |
| fill_set | input | SW | Set index of the fill |
| fill_way | input | WW | Way index of the fill |
| inv_en | input | 1 | Invalidate strobe |
| inv_set | input | SW | Set index of the invalidate |
| inv_way | input | WW | Way index of the invalidate |
| query_set | input | SW | Set whose victim is reported |
| victim_way | output | WW | Way to replace in the queried set |
| victim_free | output | 1 | 1 when the victim is an invalid way |

## Verification
The bound checker tests these properties on every cycle:
- No counter ever exceeds U-1.
- A zero counter is never decremented by an update aimed at another way.
- A hit or fill leaves its way at U-1, and an invalidate leaves its way cleared and invalid.
- The `victim_free` flag agrees with the valid flags of the queried set.
- A hit and a fill never target the same set in the same cycle.

Some behaviours involve comparisons across several ways and are shown only by the bench's scenarios, which compare every cycle against a behavioural model of the counters:
- the exact decrement rule a hit applies (only ways younger than the hit way),
- the choice of the minimum counter with ties to the lowest index,
- the priority of an invalidate over a fill to the same way,
- the one-cycle delay before an update becomes visible.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;

    // Kind of age update applied to one set in a cycle.
    typedef enum logic [1:0] {
        UPD_IDLE = 2'd0,
        UPD_HIT  = 2'd1,
        UPD_FILL = 2'd2
    } upd_kind_e;

    // Index width for a count of n items; never below one bit.
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lru_set_update.sv
// Next-state logic for the age counters and valid flags of one set.
module lru_set_update
    import lru_age_pkg::*;
#(
    parameter int NUM_WAYS   = 4,
    parameter int USE_STATES = 3,
    localparam int WW = idx_bits(NUM_WAYS),
    localparam int CW = idx_bits(USE_STATES)
) (
    input  logic [NUM_WAYS-1:0][CW-1:0] age_cur,
    input  logic [NUM_WAYS-1:0]         valid_cur,
    input  upd_kind_e                   kind,
    input  logic [WW-1:0]               upd_way,
    input  logic                        inv_here,
    input  logic [WW-1:0]               inv_way,
    output logic [NUM_WAYS-1:0][CW-1:0] age_nxt,
    output logic [NUM_WAYS-1:0]         valid_nxt
);

    localparam logic [CW-1:0] AGE_TOP = CW'(USE_STATES - 1);
    localparam logic [CW-1:0] AGE_ONE = CW'(1);

    logic [CW-1:0] ref_age;

    always_comb begin
        age_nxt   = age_cur;
        valid_nxt = valid_cur;
        ref_age   = age_cur[upd_way];

        // Age the other ways of the set by the rule of the update kind.
        for (int w = 0; w < NUM_WAYS; w++) begin
            unique case (kind)
                UPD_HIT: begin
                    if (age_cur[w] > ref_age) begin
                        age_nxt[w] = age_cur[w] - AGE_ONE;
                    end
                end
                UPD_FILL: begin
                    if (age_cur[w] != '0) begin
                        age_nxt[w] = age_cur[w] - AGE_ONE;
                    end
                end
                default: ;
            endcase
        end

        // The touched way becomes the youngest; a fill also makes it valid.
        if (kind != UPD_IDLE) begin
            age_nxt[upd_way] = AGE_TOP;
            if (kind == UPD_FILL) begin
                valid_nxt[upd_way] = 1'b1;
            end
        end

        // An invalidate decides the final state of its way.
        if (inv_here) begin
            age_nxt[inv_way]   = '0;
            valid_nxt[inv_way] = 1'b0;
        end
    end

endmodule

// File: rtl/lru_victim_pick.sv
// Victim choice for one set: lowest invalid way first, else the oldest way.
module lru_victim_pick
    import lru_age_pkg::*;
#(
    parameter int NUM_WAYS   = 4,
    parameter int USE_STATES = 3,
    localparam int WW = idx_bits(NUM_WAYS),
    localparam int CW = idx_bits(USE_STATES)
) (
    input  logic [NUM_WAYS-1:0][CW-1:0] age_set,
    input  logic [NUM_WAYS-1:0]         valid_set,
    output logic [WW-1:0]               pick_way,
    output logic                        pick_free
);

    logic [WW-1:0] free_way;
    logic          free_found;
    logic [WW-1:0] old_way;
    logic [CW-1:0] old_age;

    // Scan for the lowest-numbered invalid way.
    always_comb begin
        free_way   = '0;
        free_found = 1'b0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!valid_set[w] && !free_found) begin
                free_way   = WW'(w);
                free_found = 1'b1;
            end
        end
    end

    // Minimum age; strict compare keeps the lowest index on ties.
    always_comb begin
        old_way = '0;
        old_age = age_set[0];
        for (int w = 1; w < NUM_WAYS; w++) begin
            if (age_set[w] < old_age) begin
                old_age = age_set[w];
                old_way = WW'(w);
            end
        end
    end

    assign pick_way  = free_found ? free_way : old_way;
    assign pick_free = free_found;

endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker
    import lru_age_pkg::*;
#(
    parameter int NUM_SETS   = 8,
    parameter int NUM_WAYS   = 4,
    parameter int USE_STATES = 3,
    localparam int SW = idx_bits(NUM_SETS),
    localparam int WW = idx_bits(NUM_WAYS),
    localparam int CW = idx_bits(USE_STATES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit_en,
    input  logic [SW-1:0] hit_set,
    input  logic [WW-1:0] hit_way,
    input  logic          fill_en,
    input  logic [SW-1:0] fill_set,
    input  logic [WW-1:0] fill_way,
    input  logic          inv_en,
    input  logic [SW-1:0] inv_set,
    input  logic [WW-1:0] inv_way,
    input  logic [SW-1:0] query_set,
    output logic [WW-1:0] victim_way,
    output logic          victim_free
);

    logic [NUM_SETS-1:0][NUM_WAYS-1:0][CW-1:0] age_q;
    logic [NUM_SETS-1:0][NUM_WAYS-1:0]         valid_q;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        upd_kind_e                   kind;
        logic [WW-1:0]               uway;
        logic                        inv_here;
        logic [NUM_WAYS-1:0][CW-1:0] age_d;
        logic [NUM_WAYS-1:0][CW-1:0] age_r;
        logic [NUM_WAYS-1:0]         valid_d;
        logic [NUM_WAYS-1:0]         valid_r;

        // Route the update addressed to this set; a hit outranks a fill.
        always_comb begin
            kind = UPD_IDLE;
            uway = hit_way;
            if (hit_en && (hit_set == SW'(s))) begin
                kind = UPD_HIT;
                uway = hit_way;
            end else if (fill_en && (fill_set == SW'(s))) begin
                kind = UPD_FILL;
                uway = fill_way;
            end
        end

        assign inv_here = inv_en && (inv_set == SW'(s));

        lru_set_update #(
            .NUM_WAYS  (NUM_WAYS),
            .USE_STATES(USE_STATES)
        ) i_upd (
            .age_cur  (age_r),
            .valid_cur(valid_r),
            .kind     (kind),
            .upd_way  (uway),
            .inv_here (inv_here),
            .inv_way  (inv_way),
            .age_nxt  (age_d),
            .valid_nxt(valid_d)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                age_r   <= '0;
                valid_r <= '0;
            end else begin
                age_r   <= age_d;
                valid_r <= valid_d;
            end
        end

        assign age_q[s]   = age_r;
        assign valid_q[s] = valid_r;
    end

    lru_victim_pick #(
        .NUM_WAYS  (NUM_WAYS),
        .USE_STATES(USE_STATES)
    ) i_pick (
        .age_set  (age_q[query_set]),
        .valid_set(valid_q[query_set]),
        .pick_way (victim_way),
        .pick_free(victim_free)
    );

endmodule

// File: rtl/lru_age_tracker_chk.sv
module lru_age_tracker_chk
    import lru_age_pkg::*;
#(
    parameter int NUM_SETS   = 8,
    parameter int NUM_WAYS   = 4,
    parameter int USE_STATES = 3,
    localparam int SW = idx_bits(NUM_SETS),
    localparam int WW = idx_bits(NUM_WAYS),
    localparam int CW = idx_bits(USE_STATES)
) (
    input logic                                      clk,
    input logic                                      rst,
    input logic                                      hit_en,
    input logic [SW-1:0]                             hit_set,
    input logic [WW-1:0]                             hit_way,
    input logic                                      fill_en,
    input logic [SW-1:0]                             fill_set,
    input logic [WW-1:0]                             fill_way,
    input logic                                      inv_en,
    input logic [SW-1:0]                             inv_set,
    input logic [WW-1:0]                             inv_way,
    input logic [SW-1:0]                             query_set,
    input logic [WW-1:0]                             victim_way,
    input logic                                      victim_free,
    input logic [NUM_SETS-1:0][NUM_WAYS-1:0][CW-1:0] age_q,
    input logic [NUM_SETS-1:0][NUM_WAYS-1:0]         valid_q
);

    localparam logic [CW-1:0] AGE_TOP = CW'(USE_STATES - 1);

    AST_NO_DUAL_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !(hit_en && fill_en && (hit_set == fill_set))); // R7

    AST_HIT_TOP: assert property (@(posedge clk) disable iff (rst)
        (hit_en && !(inv_en && inv_set == hit_set && inv_way == hit_way))
        |=> age_q[$past(hit_set)][$past(hit_way)] == AGE_TOP); // R1

    AST_FILL_TOP: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !(hit_en && hit_set == fill_set)
                 && !(inv_en && inv_set == fill_set && inv_way == fill_way))
        |=> (age_q[$past(fill_set)][$past(fill_way)] == AGE_TOP)
            && valid_q[$past(fill_set)][$past(fill_way)]); // R2

    AST_INV_CLEAR: assert property (@(posedge clk) disable iff (rst)
        inv_en |=> (age_q[$past(inv_set)][$past(inv_way)] == '0)
                   && !valid_q[$past(inv_set)][$past(inv_way)]); // R4

    AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (rst)
        victim_free |-> !valid_q[query_set][victim_way]); // R6

    AST_VICTIM_FULL: assert property (@(posedge clk) disable iff (rst)
        !victim_free |-> (&valid_q[query_set])); // R6

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_cs
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cw
            AST_AGE_BOUND: assert property (@(posedge clk) disable iff (rst)
                age_q[s][w] <= AGE_TOP); // R5

            AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst)
                ((age_q[s][w] == '0)
                 && !(hit_en && hit_set == SW'(s) && hit_way == WW'(w))
                 && !(fill_en && fill_set == SW'(s) && fill_way == WW'(w)))
                |=> age_q[s][w] == '0); // R3
        end
    end

endmodule

bind lru_age_tracker lru_age_tracker_chk #(
    .NUM_SETS  (NUM_SETS),
    .NUM_WAYS  (NUM_WAYS),
    .USE_STATES(USE_STATES)
) i_lru_chk (
    .clk        (clk),
    .rst        (rst),
    .hit_en     (hit_en),
    .hit_set    (hit_set),
    .hit_way    (hit_way),
    .fill_en    (fill_en),
    .fill_set   (fill_set),
    .fill_way   (fill_way),
    .inv_en     (inv_en),
    .inv_set    (inv_set),
    .inv_way    (inv_way),
    .query_set  (query_set),
    .victim_way (victim_way),
    .victim_free(victim_free),
    .age_q      (age_q),
    .valid_q    (valid_q)
);

// File: tb/test_lru_age_tracker.sv
`timescale 1ns/100ps
module test_lru_age_tracker;

    localparam int NS = 8;
    localparam int NW = 4;
    localparam int US = 3;
    localparam int SW = 3;
    localparam int WW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          hit_en, fill_en, inv_en;
    logic [SW-1:0] hit_set, fill_set, inv_set, query_set;
    logic [WW-1:0] hit_way, fill_way, inv_way;
    logic [WW-1:0] victim_way;
    logic          victim_free;

    int checks = 0;
    int errors = 0;

    int age_m [NS][NW];
    bit val_m [NS][NW];

    always #2.5 clk = ~clk;

    lru_age_tracker #(.NUM_SETS(NS), .NUM_WAYS(NW), .USE_STATES(US)) i_lru_age_tracker (
        .clk(clk), .rst(rst),
        .hit_en(hit_en), .hit_set(hit_set), .hit_way(hit_way),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
        .inv_en(inv_en), .inv_set(inv_set), .inv_way(inv_way),
        .query_set(query_set), .victim_way(victim_way), .victim_free(victim_free)
    );

    // Behavioural model of the age rules, applied at each rising edge.
    task automatic model_apply();
        for (int s = 0; s < NS; s++) begin
            int kind = 0;
            int w = 0;
            if (hit_en && int'(hit_set) == s) begin kind = 1; w = int'(hit_way); end
            else if (fill_en && int'(fill_set) == s) begin kind = 2; w = int'(fill_way); end
            if (kind == 1) begin
                int ref_a = age_m[s][w];
                for (int o = 0; o < NW; o++)
                    if (o != w && age_m[s][o] > ref_a) age_m[s][o]--;
                age_m[s][w] = US - 1;
            end else if (kind == 2) begin
                for (int o = 0; o < NW; o++)
                    if (o != w && age_m[s][o] > 0) age_m[s][o]--;
                age_m[s][w] = US - 1;
                val_m[s][w] = 1'b1;
            end
            if (inv_en && int'(inv_set) == s) begin
                age_m[s][int'(inv_way)] = 0;
                val_m[s][int'(inv_way)] = 1'b0;
            end
        end
    endtask

    task automatic model_victim(input int s, output int w, output bit f);
        int best;
        w = 0; f = 1'b0;
        for (int i = 0; i < NW; i++)
            if (!val_m[s][i] && !f) begin w = i; f = 1'b1; end
        if (!f) begin
            best = age_m[s][0];
            for (int i = 1; i < NW; i++)
                if (age_m[s][i] < best) begin best = age_m[s][i]; w = i; end
        end
    endtask

    task automatic check_victim(input int exp_w, input bit exp_f, input string tag);
        checks++;
        if (int'(victim_way) != exp_w || victim_free !== exp_f) begin
            errors++;
            $display("FAIL %s: set %0d victim way=%0d free=%0b, expected way=%0d free=%0b",
                     tag, query_set, victim_way, victim_free, exp_w, exp_f);
        end
    endtask

    task automatic clear_ops();
        hit_en = 1'b0; fill_en = 1'b0; inv_en = 1'b0;
    endtask

    // One clocked operation: drive at the falling edge, model at the rising edge.
    task automatic op(input bit he, input int hs, input int hw,
                      input bit fe, input int fs, input int fw,
                      input bit ie, input int is, input int iw);
        @(negedge clk);
        hit_en = he;  hit_set = SW'(hs);  hit_way = WW'(hw);
        fill_en = fe; fill_set = SW'(fs); fill_way = WW'(fw);
        inv_en = ie;  inv_set = SW'(is);  inv_way = WW'(iw);
        @(posedge clk);
        model_apply();
        #1;
        clear_ops();
    endtask

    task automatic peek(input int s);
        @(negedge clk);
        query_set = SW'(s);
        #1;
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int ew;
        bit ef;
        rst = 1'b1;
        clear_ops();
        hit_set = '0; fill_set = '0; inv_set = '0; query_set = '0;
        hit_way = '0; fill_way = '0; inv_way = '0;
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin age_m[s][w] = 0; val_m[s][w] = 1'b0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R10: every set empty after reset.
        for (int s = 0; s < NS; s++) begin
            peek(s);
            check_victim(0, 1'b1, "R10 reset state");
        end

        // R2: fill all ways of set 2 -> ages 0,0,1,2.
        for (int w = 0; w < NW; w++) op(0,0,0, 1,2,w, 0,0,0);
        peek(2); check_victim(0, 1'b0, "R2 fill sequence / R6 tie to lowest");

        // R3: refill way 3 -> ages 0,0,0,2; zero counters must not wrap.
        op(0,0,0, 1,2,3, 0,0,0);
        peek(2); check_victim(0, 1'b0, "R3 no decrement below zero");

        // R1: hits -> ages 2,0,0,1 then 1,0,0,2 then 0,2,0,1.
        op(1,2,0, 0,0,0, 0,0,0);
        peek(2); check_victim(1, 1'b0, "R1 hit ages younger ways");
        op(1,2,3, 0,0,0, 0,0,0);
        peek(2); check_victim(1, 1'b0, "R1 hit on middle age");
        op(1,2,1, 0,0,0, 0,0,0);
        peek(2); check_victim(0, 1'b0, "R1 hit on oldest way");

        // R4 / R6: invalidate way 2 -> preferred over older valid way 0.
        op(0,0,0, 0,0,0, 1,2,2);
        peek(2); check_victim(2, 1'b1, "R4 invalidate / R6 invalid preferred");

        // R2: fill way 2 -> ages 0,1,2,0.
        op(0,0,0, 1,2,2, 0,0,0);
        peek(2); check_victim(0, 1'b0, "R2 fill decrements non-zero ways");

        // R7: hit set 2 way 0 and fill set 4 way 0 together.
        op(1,2,0, 1,4,0, 0,0,0);
        peek(2); check_victim(1, 1'b0, "R7 hit beside fill, hit set");
        peek(4); check_victim(1, 1'b1, "R7 hit beside fill, fill set");

        // R8: fill and invalidate the same way -> invalidate wins.
        op(0,0,0, 1,2,1, 1,2,1);
        peek(2); check_victim(1, 1'b1, "R8 invalidate wins over fill");

        // R9: update not visible before the edge; query switches without a clock.
        @(negedge clk);
        fill_en = 1'b1; fill_set = SW'(2); fill_way = WW'(1);
        query_set = SW'(2);
        #1 check_victim(1, 1'b1, "R9 update not visible before edge");
        query_set = SW'(5);
        #0.5 check_victim(0, 1'b1, "R9 victim follows query combinationally");
        query_set = SW'(2);
        @(posedge clk);
        model_apply();
        #1 clear_ops();
        peek(2); check_victim(0, 1'b0, "R9 update visible after edge");

        // Random traffic compared with the model every cycle (R5 R6).
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            hit_en   = ($urandom_range(0, 2) == 0);
            hit_set  = SW'($urandom_range(0, NS - 1));
            hit_way  = WW'($urandom_range(0, NW - 1));
            fill_en  = ($urandom_range(0, 2) == 0);
            fill_set = SW'($urandom_range(0, NS - 1));
            fill_way = WW'($urandom_range(0, NW - 1));
            inv_en   = ($urandom_range(0, 5) == 0);
            inv_set  = SW'($urandom_range(0, NS - 1));
            inv_way  = WW'($urandom_range(0, NW - 1));
            query_set = SW'($urandom_range(0, NS - 1));
            if (hit_en && fill_en && hit_set == fill_set) fill_en = 1'b0;
            #1;
            model_victim(int'(query_set), ew, ef);
            check_victim(ew, ef, "R5 R6 random traffic vs model");
            @(posedge clk);
            model_apply();
        end
        #1 clear_ops();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule